// File: doc/BRIEF.md
# ADC auto conversion sequencer

This block drives an external conversion core through a start/done handshake. It holds a table of sixteen slots, and each slot carries a 4-bit channel code. The block walks these slots, asks the core for one conversion per slot, and stores each 12-bit result, left-justified, in the result register that has the same index as the slot. Software or event logic supplies start pulses that are already qualified, and a soft reset for each sequencer. The block reports a one-cycle end-of-session pulse and the live pointer of each sequencer.

The slots can be used in two layouts.

- **Split layout.** Sequencer A owns slots 0 to 7 and sequencer B owns slots 8 to 15. The two run independently and share the core. A fixed-priority grant favours A, and only one conversion is ever outstanding.
- **Joined layout.** Sequencer A alone walks all sixteen slots, and sequencer B is held parked.

Each session converts a programmed number of slots, counting from wherever the pointer last stopped. The pointer then waits for the next start. In continuous mode the sequencer rearms itself, and a wrap flag chooses when the pointer returns to its initial slot.

Top module: `adc_autoseq`

## Requirements
- R1: With `cascade_i`=0, sequencer A converts only slots 0..7 and sequencer B only slots 8..15. A pointer that advances past its end slot (7 for A, 15 for B) returns to its initial slot (0 for A, 8 for B).
- R2: With `cascade_i`=1, sequencer A walks slots 0..15, wraps from 15 to 0 and takes its count from all four bits of `cnt_a_i`. Sequencer B is held at slot 8, and `start_b_i` causes no conversion.
- R3: The channel code of slot n is `chan_tbl_i[4n+3:4n]`. In the cycle that `conv_start_o` is high, `conv_chan_o` carries the code of the slot being converted.
- R4: A session performs exactly (count field + 1) conversions. At its end, the sequencer's `eos_*_o` is high for exactly one cycle.
- R5: After a session, the pointer stays on the slot that follows the last one converted. The next start resumes from that slot.
- R6: The result of slot n is stored in result register n as {12-bit value, 4'b0000}. `rd_data_o` shows register `rd_addr_i` one clock after the address is applied.
- R7: With continuous mode on and the wrap flag at 0, the sequencer starts a new session on its own after each session. Each new session begins at the initial slot.
- R8: With continuous mode on and the wrap flag at 1, the sequencer also restarts on its own. In this case the pointer keeps advancing and returns to the initial slot only after the end slot.
- R9: A soft reset puts the pointer on its initial slot by the next clock, and it cancels both the current session and any held start. A conversion already in flight still writes its slot's result but does not move the pointer.
- R10: When both sequencers have work in the split layout, sequencer A's conversion is issued first. A new `conv_start_o` is never issued while an earlier conversion is still waiting for `conv_done_i`.
- R11: A start that arrives while its sequencer is busy is held. Once the current session ends, a second session follows at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade_i | input | 1 | 0 = two sequencers, 1 = one 16-slot sequencer |
| chan_tbl_i | input | 64 | Sixteen packed 4-bit channel codes, slot n at bits 4n+3:4n |
| cnt_a_i | input | 4 | Sequencer A count field (low 3 bits used in split layout) |
| cnt_b_i | input | 3 | Sequencer B count field |
| cont_a_i | input | 1 | Sequencer A continuous mode |
| cont_b_i | input | 1 | Sequencer B continuous mode |
| wrap_end_a_i | input | 1 | Sequencer A: wrap at end slot instead of at count |
| wrap_end_b_i | input | 1 | Sequencer B: wrap at end slot instead of at count |
| start_a_i | input | 1 | Start pulse for sequencer A |
| start_b_i | input | 1 | Start pulse for sequencer B |
| clr_a_i | input | 1 | Soft reset of sequencer A |
| clr_b_i | input | 1 | Soft reset of sequencer B |
| conv_start_o | output | 1 | One-cycle request to the conversion core |
| conv_chan_o | output | 4 | Channel code for the requested conversion |
| conv_done_i | input | 1 | Core reports a finished conversion |
| conv_data_i | input | 12 | Conversion value, valid with conv_done_i |
| rd_addr_i | input | 4 | Result register index to read |
| rd_data_o | output | 16 | Registered read data |
| eos_a_o | output | 1 | Sequencer A end-of-session pulse |
| eos_b_o | output | 1 | Sequencer B end-of-session pulse |
| ptr_a_o | output | 4 | Sequencer A current slot |
| ptr_b_o | output | 4 | Sequencer B current slot |

## Verification
The bench builds the block with its default parameters: sixteen slots, 4-bit channel codes and 12-bit values. It pairs the block with a converter model whose latency is four clocks. The model's output is derived from the channel code, so every stored result shows which slot it came from.

With these values a session of up to sixteen conversions fits in a few hundred cycles. That brings within reach the wrap at slot 7, at slot 15 and at slot 15 in the joined layout, as well as both continuous-mode wrap choices, held starts, and a soft reset that lands mid-conversion.

// File: rtl/adc_autoseq_pkg.sv
package adc_autoseq_pkg;
  typedef enum logic {SEQ_A = 1'b0, SEQ_B = 1'b1} seq_id_e;
  localparam int unsigned N_SEQ = 2;
endpackage

// File: rtl/adc_autoseq_seq.sv
module adc_autoseq_seq #(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] init_slot,
  input  logic [SW-1:0] end_slot,
  input  logic [SW-1:0] cnt_field,
  input  logic          cont,
  input  logic          wrap_end,
  input  logic          start,
  input  logic          clr,
  input  logic          adv,
  output logic          busy,
  output logic [SW-1:0] ptr,
  output logic          eos
);
  localparam int unsigned NW = SW + 1;

  logic          pend;
  logic [NW-1:0] left;
  logic [NW-1:0] reload;
  logic [SW-1:0] ptr_nxt;

  assign reload  = {1'b0, cnt_field} + NW'(1);
  assign ptr_nxt = (ptr == end_slot) ? init_slot : ptr + SW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr  <= init_slot;
      busy <= 1'b0;
      pend <= 1'b0;
      left <= '0;
      eos  <= 1'b0;
    end else begin
      eos <= 1'b0;
      if (!busy) begin
        if (start || pend) begin
          busy <= 1'b1;
          left <= reload;
          pend <= 1'b0;
        end
      end else begin
        if (start) pend <= 1'b1;
        if (adv) begin
          if (left == NW'(1)) begin
            eos <= 1'b1;
            if (cont) begin
              left <= reload;
              ptr  <= wrap_end ? ptr_nxt : init_slot;
            end else if (pend || start) begin
              left <= reload;
              pend <= 1'b0;
              ptr  <= ptr_nxt;
            end else begin
              busy <= 1'b0;
              ptr  <= ptr_nxt;
            end
          end else begin
            left <= left - NW'(1);
            ptr  <= ptr_nxt;
          end
        end
      end
    end
  end

  // R9
  clr_init_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (ptr == $past(init_slot)));

  // R4
  eos_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eos |=> !eos);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !clr) |=> $stable(ptr));

  // R1
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr >= init_slot) && (ptr <= end_slot));
endmodule

// File: rtl/adc_autoseq_engine.sv
module adc_autoseq_engine
  import adc_autoseq_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned CW    = 4,
  parameter int unsigned DW    = 12,
  parameter int unsigned RW    = 16,
  parameter int unsigned SW    = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SEQ-1:0]  req,
  input  logic [N_SEQ-1:0]  clr,
  input  logic [SW-1:0]     ptr_a,
  input  logic [SW-1:0]     ptr_b,
  input  logic [NSLOT*CW-1:0] chan_tbl,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_data,
  output logic              conv_start,
  output logic [CW-1:0]     conv_chan,
  output logic [N_SEQ-1:0]  adv,
  output logic              we,
  output logic [SW-1:0]     waddr,
  output logic [RW-1:0]     wdata
);
  localparam int unsigned PADW = RW - DW;

  logic          inflight;
  seq_id_e       owner;
  logic [SW-1:0] slot;
  logic          drop;
  logic          clr_own;

  assign clr_own = (owner == SEQ_A) ? clr[0] : clr[1];

  always_comb begin
    adv = '0;
    if (inflight && conv_done && !drop)
      adv[owner] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inflight   <= 1'b0;
      owner      <= SEQ_A;
      slot       <= '0;
      drop       <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      we         <= 1'b0;
      waddr      <= '0;
      wdata      <= '0;
    end else begin
      conv_start <= 1'b0;
      we         <= 1'b0;
      if (!inflight) begin
        if (req[0]) begin
          inflight   <= 1'b1;
          owner      <= SEQ_A;
          slot       <= ptr_a;
          conv_chan  <= chan_tbl[ptr_a*CW +: CW];
          conv_start <= 1'b1;
          drop       <= clr[0];
        end else if (req[1]) begin
          inflight   <= 1'b1;
          owner      <= SEQ_B;
          slot       <= ptr_b;
          conv_chan  <= chan_tbl[ptr_b*CW +: CW];
          conv_start <= 1'b1;
          drop       <= clr[1];
        end
      end else begin
        drop <= drop | clr_own;
        if (conv_done) begin
          inflight <= 1'b0;
          we       <= 1'b1;
          waddr    <= slot;
          wdata    <= {conv_data, {PADW{1'b0}}};
        end
      end
    end
  end

  // R10
  one_flight_chk: assert property (@(posedge clk) disable iff (rst)
    (inflight && !conv_done) |=> !conv_start);

  // R10
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    (!inflight && req[0] && req[1]) |=> (conv_start && owner == SEQ_A));
endmodule

// File: rtl/adc_autoseq_ram.sv
module adc_autoseq_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned RW    = 16,
  parameter int unsigned PADW  = 4,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [RW-1:0] rdata
);
  logic [RW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R6
  wr_format_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (wdata[PADW-1:0] == '0));
endmodule

// File: rtl/adc_autoseq.sv
module adc_autoseq
  import adc_autoseq_pkg::*;
#(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned CW    = 4,
  parameter int unsigned DW    = 12,
  parameter int unsigned RW    = 16,
  parameter int unsigned SW    = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cascade_i,
  input  logic [NSLOT*CW-1:0] chan_tbl_i,
  input  logic [SW-1:0]       cnt_a_i,
  input  logic [SW-2:0]       cnt_b_i,
  input  logic                cont_a_i,
  input  logic                cont_b_i,
  input  logic                wrap_end_a_i,
  input  logic                wrap_end_b_i,
  input  logic                start_a_i,
  input  logic                start_b_i,
  input  logic                clr_a_i,
  input  logic                clr_b_i,
  output logic                conv_start_o,
  output logic [CW-1:0]       conv_chan_o,
  input  logic                conv_done_i,
  input  logic [DW-1:0]       conv_data_i,
  input  logic [SW-1:0]       rd_addr_i,
  output logic [RW-1:0]       rd_data_o,
  output logic                eos_a_o,
  output logic                eos_b_o,
  output logic [SW-1:0]       ptr_a_o,
  output logic [SW-1:0]       ptr_b_o
);
  localparam logic [SW-1:0] HALF = SW'(NSLOT / 2);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  logic [SW-1:0]    init_s [N_SEQ];
  logic [SW-1:0]    end_s  [N_SEQ];
  logic [SW-1:0]    cnt_s  [N_SEQ];
  logic [SW-1:0]    ptr_s  [N_SEQ];
  logic [N_SEQ-1:0] cont_s, wrap_s, start_s, clr_s, adv_s, busy_s, eos_s, req_s;

  logic          we;
  logic [SW-1:0] waddr;
  logic [RW-1:0] wdata;

  assign init_s[0]  = '0;
  assign end_s[0]   = cascade_i ? LAST : HALF - SW'(1);
  assign cnt_s[0]   = cascade_i ? cnt_a_i : {1'b0, cnt_a_i[SW-2:0]};
  assign cont_s[0]  = cont_a_i;
  assign wrap_s[0]  = wrap_end_a_i;
  assign start_s[0] = start_a_i;
  assign clr_s[0]   = clr_a_i;

  assign init_s[1]  = HALF;
  assign end_s[1]   = LAST;
  assign cnt_s[1]   = {1'b0, cnt_b_i};
  assign cont_s[1]  = cont_b_i;
  assign wrap_s[1]  = wrap_end_b_i;
  assign start_s[1] = start_b_i & ~cascade_i;
  assign clr_s[1]   = clr_b_i | cascade_i;

  for (genvar g = 0; g < N_SEQ; g++) begin : g_seq
    adc_autoseq_seq #(.SW(SW)) seq_i (
      .clk      (clk),
      .rst      (rst),
      .init_slot(init_s[g]),
      .end_slot (end_s[g]),
      .cnt_field(cnt_s[g]),
      .cont     (cont_s[g]),
      .wrap_end (wrap_s[g]),
      .start    (start_s[g]),
      .clr      (clr_s[g]),
      .adv      (adv_s[g]),
      .busy     (busy_s[g]),
      .ptr      (ptr_s[g]),
      .eos      (eos_s[g])
    );
  end

  assign req_s = busy_s & ~clr_s;

  adc_autoseq_engine #(.NSLOT(NSLOT), .CW(CW), .DW(DW), .RW(RW), .SW(SW)) eng_i (
    .clk       (clk),
    .rst       (rst),
    .req       (req_s),
    .clr       (clr_s),
    .ptr_a     (ptr_s[0]),
    .ptr_b     (ptr_s[1]),
    .chan_tbl  (chan_tbl_i),
    .conv_done (conv_done_i),
    .conv_data (conv_data_i),
    .conv_start(conv_start_o),
    .conv_chan (conv_chan_o),
    .adv       (adv_s),
    .we        (we),
    .waddr     (waddr),
    .wdata     (wdata)
  );

  adc_autoseq_ram #(.DEPTH(NSLOT), .RW(RW), .PADW(RW - DW), .AW(SW)) ram_i (
    .clk  (clk),
    .rst  (rst),
    .we   (we),
    .waddr(waddr),
    .wdata(wdata),
    .raddr(rd_addr_i),
    .rdata(rd_data_o)
  );

  assign eos_a_o = eos_s[0];
  assign eos_b_o = eos_s[1];
  assign ptr_a_o = ptr_s[0];
  assign ptr_b_o = ptr_s[1];

  // R2
  park_b_chk: assert property (@(posedge clk) disable iff (rst)
    cascade_i |=> (ptr_b_o == HALF));
endmodule

// File: tb/adc_autoseq_tb_top.sv
`timescale 1ns/1ps
module adc_autoseq_tb_top;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cascade = 1'b0;
  logic [63:0] tbl;
  logic [3:0]  cnt_a = '0;
  logic [2:0]  cnt_b = '0;
  logic        cont_a = 1'b0, cont_b = 1'b0, wrap_a = 1'b0, wrap_b = 1'b0;
  logic        start_a = 1'b0, start_b = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        eos_a, eos_b;
  logic [3:0]  ptr_a, ptr_b;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  adc_autoseq dut_i (
    .clk(clk), .rst(rst), .cascade_i(cascade), .chan_tbl_i(tbl),
    .cnt_a_i(cnt_a), .cnt_b_i(cnt_b), .cont_a_i(cont_a), .cont_b_i(cont_b),
    .wrap_end_a_i(wrap_a), .wrap_end_b_i(wrap_b),
    .start_a_i(start_a), .start_b_i(start_b), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .eos_a_o(eos_a), .eos_b_o(eos_b), .ptr_a_o(ptr_a), .ptr_b_o(ptr_b)
  );

  function automatic logic [3:0] t1(input int n); return 4'((n * 7 + 3) & 15); endfunction
  function automatic logic [3:0] t2(input int n); return 4'((n * 5 + 1) & 15); endfunction
  function automatic logic [11:0] fval(input logic [3:0] c); return {c, ~c, c ^ 4'h9}; endfunction
  function automatic logic [63:0] mk_tbl(input bit second);
    logic [63:0] v;
    for (int n = 0; n < 16; n++) v[n*4 +: 4] = second ? t2(n) : t1(n);
    return v;
  endfunction

  // converter model
  int cnt_m = 0;
  logic [3:0] ch_m = '0;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (cnt_m > 0) begin
      if (cnt_m == 1) begin
        conv_done <= 1'b1;
        conv_data <= fval(ch_m);
      end
      cnt_m <= cnt_m - 1;
    end
    if (conv_start) begin
      cnt_m <= LAT;
      ch_m  <= conv_chan;
    end
  end

  // monitor
  logic [3:0] clog [512];
  int nlog = 0, neos_a = 0, neos_b = 0, overlap = 0;
  bit outstanding = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (conv_start) begin
        if (outstanding) overlap++;
        outstanding = 1;
        if (nlog < 512) clog[nlog] = conv_chan;
        nlog++;
      end
      if (conv_done) outstanding = 0;
      if (eos_a) neos_a++;
      if (eos_b) neos_b++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input bit a, input bit b);
    start_a = a; start_b = b;
    @(negedge clk);
    start_a = 0; start_b = 0;
  endtask

  task automatic wait_eos_a(input int target);
    int i = 0;
    while (neos_a < target && i < 3000) begin @(negedge clk); i++; end
  endtask

  task automatic wait_log(input int target);
    int i = 0;
    while (nlog < target && i < 3000) begin @(negedge clk); i++; end
  endtask

  task automatic read_chk(input string req, input int addr, input logic [3:0] ch);
    rd_addr = 4'(addr);
    @(negedge clk);
    chk(req, rd_data, {fval(ch), 4'b0000});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // vectors: {count field, expected pointer after the session}
  localparam logic [7:0] VEC [6] = '{8'h23, 8'h15, 8'h31, 8'h71, 8'h02, 8'h47};

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base, e0;
    tbl = mk_tbl(0);
    cyc(4);
    rst = 0;
    @(negedge clk);
    // reset state
    chk("R1 reset ptr_a", ptr_a, 0);
    chk("R1 reset ptr_b", ptr_b, 8);
    chk("R4 reset eos", {eos_a, eos_b}, 0);
    chk("R10 reset conv_start", conv_start, 0);

    // vector walk, split layout, sequencer A
    for (int v = 0; v < 6; v++) begin
      base = nlog; e0 = neos_a;
      cnt_a = {1'b0, VEC[v][6:4]};
      pulse_start(1, 0);
      wait_eos_a(e0 + 1);
      chk("R4 conversions per session", nlog - base, VEC[v][7:4] + 1);
      chk("R5 pointer after session", ptr_a, VEC[v][3:0]);
      if (v == 0) chk("R3 first channel code", clog[base], t1(0));
    end
    cyc(2);
    chk("R4 single eos per session", neos_a, 6);
    for (int n = 0; n < 8; n++) read_chk("R6 result A", n, t1(n));

    // sequencer B
    base = nlog; e0 = neos_b;
    cnt_b = 3'd2;
    pulse_start(0, 1);
    cyc(60);
    chk("R1 B conversions", nlog - base, 3);
    chk("R1 B pointer", ptr_b, 11);
    cnt_b = 3'd6;
    pulse_start(0, 1);
    cyc(120);
    chk("R1 B wrap 15 to 8", ptr_b, 10);
    chk("R4 B eos count", neos_b - e0, 2);
    for (int n = 8; n < 16; n++) read_chk("R6 result B", n, t1(n));

    // priority: A at 7, B at 10
    base = nlog;
    cnt_a = 4'd0; cnt_b = 3'd0;
    pulse_start(1, 1);
    cyc(60);
    chk("R10 A served first", clog[base], t1(7));
    chk("R10 B served second", clog[base + 1], t1(10));
    chk("R1 A wrap 7 to 0", ptr_a, 0);
    chk("R1 B pointer after one", ptr_b, 11);

    // held start
    base = nlog; e0 = neos_a;
    cnt_a = 4'd1;
    pulse_start(1, 0);
    cyc(3);
    pulse_start(1, 0);
    cyc(150);
    chk("R11 two sessions conversions", nlog - base, 4);
    chk("R11 pointer", ptr_a, 4);
    chk("R11 eos count", neos_a - e0, 2);

    // continuous, wrap at count
    base = nlog;
    cont_a = 1; wrap_a = 0; cnt_a = 4'd1;
    pulse_start(1, 0);
    wait_log(base + 5);
    cont_a = 0;
    chk("R7 slot seq 0", clog[base],     t1(4));
    chk("R7 slot seq 1", clog[base + 1], t1(5));
    chk("R7 slot seq 2", clog[base + 2], t1(0));
    chk("R7 slot seq 3", clog[base + 3], t1(1));
    chk("R7 slot seq 4", clog[base + 4], t1(0));
    cyc(150);
    clr_a = 1; @(negedge clk); clr_a = 0;

    // continuous, wrap at end slot
    base = nlog;
    cont_a = 1; wrap_a = 1; cnt_a = 4'd2;
    pulse_start(1, 0);
    wait_log(base + 10);
    cont_a = 0;
    for (int k = 0; k < 10; k++) chk("R8 slot seq", clog[base + k], t1(k % 8));
    cyc(150);
    clr_a = 1; @(negedge clk); clr_a = 0;
    wrap_a = 0;

    // soft reset during a conversion
    tbl = mk_tbl(1);
    base = nlog;
    cnt_a = 4'd7;
    pulse_start(1, 0);
    wait_log(base + 1);
    @(negedge clk);
    clr_a = 1; @(negedge clk); clr_a = 0;
    chk("R9 pointer to initial", ptr_a, 0);
    cyc(100);
    chk("R9 no further conversions", nlog - base, 1);
    chk("R9 pointer not advanced", ptr_a, 0);
    read_chk("R9 in-flight result written", 0, t2(0));
    read_chk("R9 next slot untouched", 1, t1(1));

    // joined layout
    cascade = 1;
    @(negedge clk);
    base = nlog; e0 = neos_a;
    cnt_a = 4'd11;
    pulse_start(1, 0);
    pulse_start(0, 1);
    wait_eos_a(e0 + 1);
    chk("R2 joined conversions", nlog - base, 12);
    chk("R2 joined pointer", ptr_a, 12);
    base = nlog;
    cnt_a = 4'd5;
    pulse_start(1, 0);
    wait_eos_a(e0 + 2);
    chk("R2 joined wrap 15 to 0", ptr_a, 2);
    chk("R2 joined conversions 2", nlog - base, 6);
    chk("R2 B parked", ptr_b, 8);
    cyc(20);
    chk("R2 start_b ignored", nlog - base, 6);
    for (int n = 12; n < 16; n++) read_chk("R6 joined result", n, t2(n));
    cascade = 0;
    @(negedge clk);

    chk("R10 no overlapping conversions", overlap, 0);
    finish_run();
  end
endmodule